// File: doc/BRIEF.md
# Trace-Driven Traffic Injector

This block stands in for a processing element when a packet network is under test. It walks through a small trace memory and turns each packet record into one head flit and a number of body flits on a valid/backpressure output channel. Two kinds of marker word shape the stream. A step marker parks the injector until a global barrier input releases it. An end marker stops it for good. A six-bit rate input throttles how often a flit may leave, in sixty-fourths of the clock rate.

On its receive side the block counts the flits the network delivers to it. It raises a completion flag while that count equals an expected total given on an input. The trace memory is written through a simple load port while the run input is low. Once run goes high, the sequencer starts at address 0.

Top module: `traffic_injector`

## Requirements
- R1: After reset, out_valid is 0, the trace pointer is 0, no rate credit is held, and the receive count is 0, so done is 0 for any nonzero rx_expected.
- R2: A trace word with its top bit 0 is a packet record laid out, from the top down, as {0, dx[X_W], dy[Y_W], len[LEN_W]}. A record with len at least 1 produces exactly len flits: one head flit followed by len-1 body flits. Records are played in address order.
- R3: A head flit is {1, dx, dy, len, PAY_W zero bits}. The k-th body flit of a packet (k = 1 .. len-1) has its top bit 0, its low PAY_W bits equal to k, and zeros in between.
- R4: A packet record with len 0 produces no flit. So does a word with its top bit 1 whose other bits are neither all zero nor all one. The sequencer skips both kinds of word.
- R5: A word with its top bit 1 and all other bits 0 is a step marker. After it, no flit is offered until step_go is sampled high.
- R6: A word with its top bit 1 and all other bits 1 is an end marker. After it, no flit is offered again until reset.
- R7: A six-bit accumulator adds rate every cycle, and each carry out grants one send credit. At most one credit is held at a time, and each sent flit consumes it. With rate 0 no flit is ever sent. With rate 16 and no backpressure, a steady stream sends 32 plus or minus 1 flits in any 128 cycles.
- R8: A flit transfers in a cycle with out_valid high and out_bp low. While out_valid is high and out_bp is high, out_valid stays high and out_flit is unchanged in the next cycle.
- R9: Trace words are written via ld_we/ld_addr/ld_word while run is low. The sequencer leaves idle when run is first seen high, and it reads from address 0 onward. The address wraps past the last entry.
- R10: Every cycle with in_valid high adds one to the receive count. done is high exactly while that count equals rx_expected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Trace memory write enable |
| ld_addr | input | ROM_AW | Trace memory write address |
| ld_word | input | 1+X_W+Y_W+LEN_W | Trace word to store |
| run | input | 1 | Start playing the trace |
| rate | input | RATE_W | Injection rate in 1/64 units |
| step_go | input | 1 | Barrier release for a step marker |
| out_valid | output | 1 | Flit offered on the output channel |
| out_flit | output | 1+X_W+Y_W+LEN_W+PAY_W | Offered flit |
| out_bp | input | 1 | Downstream backpressure |
| in_valid | input | 1 | A flit arrives from the network |
| rx_expected | input | CNT_W | Expected total of received flits |
| done | output | 1 | Receive count equals rx_expected |

## Verification
The bench builds the block with X_W=3, Y_W=3, LEN_W=4, PAY_W=6, ROM_AW=5, RATE_W=6 and CNT_W=8. The four-bit length allows 15-flit packets, so three back-to-back packets keep the stream busy across a whole 128-cycle rate window. The 32-word trace fits skipped words, a step marker and an end marker all in one run. The eight-bit counter lets the receive total pass rx_expected and shows done falling again.

// File: rtl/traffic_injector_pkg.sv
package traffic_injector_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_HEAD,
    SQ_BODY,
    SQ_WAIT,
    SQ_END
  } seq_state_t;
endpackage

// File: rtl/inj_rate_gate.sv
module inj_rate_gate #(
  parameter int RATE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              take,
  output logic              credit,
  output logic              carry
);
  logic [RATE_W-1:0] acc;
  logic [RATE_W:0]   sum;

  function automatic logic [RATE_W:0] acc_sum(input logic [RATE_W-1:0] a,
                                              input logic [RATE_W-1:0] r);
    return {1'b0, a} + {1'b0, r};
  endfunction

  assign sum   = acc_sum(acc, rate);
  assign carry = sum[RATE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      credit <= 1'b0;
    end else begin
      acc    <= sum[RATE_W-1:0];
      credit <= (credit & ~take) | carry;
    end
  end
endmodule

// File: rtl/inj_trace_seq.sv
module inj_trace_seq
  import traffic_injector_pkg::*;
#(
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int LEN_W  = 4,
  parameter int PAY_W  = 6,
  parameter int ROM_AW = 5,
  localparam int TW    = 1 + X_W + Y_W + LEN_W,
  localparam int FW    = TW + PAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [ROM_AW-1:0] ld_addr,
  input  logic [TW-1:0]     ld_word,
  input  logic              run,
  input  logic              step_go,
  input  logic              credit,
  input  logic              out_bp,
  output logic              out_valid,
  output logic [FW-1:0]     out_flit,
  output logic              take,
  output logic              at_barrier,
  output logic              finished
);
  localparam int DEPTH = 1 << ROM_AW;

  logic [TW-1:0]     rom [DEPTH];
  logic [ROM_AW-1:0] ptr;
  seq_state_t        st;
  logic [X_W-1:0]    dx_q;
  logic [Y_W-1:0]    dy_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  left_q;
  logic [PAY_W-1:0]  seq_q;
  logic [TW-1:0]     word;
  logic [LEN_W-1:0]  w_len;
  logic [Y_W-1:0]    w_dy;
  logic [X_W-1:0]    w_dx;

  function automatic logic is_step(input logic [TW-1:0] w);
    return w[TW-1] && (w[TW-2:0] == '0);
  endfunction

  function automatic logic is_end(input logic [TW-1:0] w);
    return w[TW-1] && (&w[TW-2:0]);
  endfunction

  function automatic logic [FW-1:0] make_head(input logic [X_W-1:0] dx,
                                              input logic [Y_W-1:0] dy,
                                              input logic [LEN_W-1:0] ln);
    return {1'b1, dx, dy, ln, {PAY_W{1'b0}}};
  endfunction

  function automatic logic [FW-1:0] make_body(input logic [PAY_W-1:0] k);
    return {1'b0, {(TW-1){1'b0}}, k};
  endfunction

  always_ff @(posedge clk) begin
    if (ld_we) rom[ld_addr] <= ld_word;
  end

  assign word  = rom[ptr];
  assign w_len = word[LEN_W-1:0];
  assign w_dy  = word[LEN_W +: Y_W];
  assign w_dx  = word[LEN_W+Y_W +: X_W];

  assign out_valid  = credit && (st == SQ_HEAD || st == SQ_BODY);
  assign take       = out_valid && !out_bp;
  assign out_flit   = (st == SQ_BODY) ? make_body(seq_q) : make_head(dx_q, dy_q, len_q);
  assign at_barrier = (st == SQ_WAIT);
  assign finished   = (st == SQ_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      ptr    <= '0;
      dx_q   <= '0;
      dy_q   <= '0;
      len_q  <= '0;
      left_q <= '0;
      seq_q  <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (run) st <= SQ_FETCH;
        SQ_FETCH: begin
          if (is_end(word)) begin
            st <= SQ_END;
          end else if (is_step(word)) begin
            st  <= SQ_WAIT;
            ptr <= ptr + 1'b1;
          end else if (!word[TW-1] && w_len != '0) begin
            dx_q   <= w_dx;
            dy_q   <= w_dy;
            len_q  <= w_len;
            left_q <= w_len;
            seq_q  <= PAY_W'(1);
            st     <= SQ_HEAD;
            ptr    <= ptr + 1'b1;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        SQ_HEAD: if (take) begin
          if (left_q == LEN_W'(1)) st <= SQ_FETCH;
          else st <= SQ_BODY;
          left_q <= left_q - 1'b1;
        end
        SQ_BODY: if (take) begin
          seq_q  <= seq_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) st <= SQ_FETCH;
        end
        SQ_WAIT: if (step_go) st <= SQ_FETCH;
        default: st <= SQ_END;
      endcase
    end
  end
endmodule

// File: rtl/inj_rx_tally.sv
module inj_rx_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] rx_expected,
  output logic [CNT_W-1:0] rx_count,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (!rst_n) rx_count <= '0;
    else if (in_valid) rx_count <= rx_count + 1'b1;
  end

  assign done = (rx_count == rx_expected);
endmodule

// File: rtl/traffic_injector.sv
module traffic_injector #(
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int LEN_W  = 4,
  parameter int PAY_W  = 6,
  parameter int ROM_AW = 5,
  parameter int RATE_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ld_we,
  input  logic [ROM_AW-1:0]                 ld_addr,
  input  logic [X_W+Y_W+LEN_W:0]            ld_word,
  input  logic                              run,
  input  logic [RATE_W-1:0]                 rate,
  input  logic                              step_go,
  output logic                              out_valid,
  output logic [X_W+Y_W+LEN_W+PAY_W:0]      out_flit,
  input  logic                              out_bp,
  input  logic                              in_valid,
  input  logic [CNT_W-1:0]                  rx_expected,
  output logic                              done
);
  logic             credit;
  logic             carry;
  logic             take;
  logic             at_barrier;
  logic             finished;
  logic [CNT_W-1:0] rx_count;

  inj_rate_gate #(.RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .rate(rate), .take(take),
    .credit(credit), .carry(carry)
  );

  inj_trace_seq #(
    .X_W(X_W), .Y_W(Y_W), .LEN_W(LEN_W), .PAY_W(PAY_W), .ROM_AW(ROM_AW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_word(ld_word),
    .run(run), .step_go(step_go), .credit(credit), .out_bp(out_bp),
    .out_valid(out_valid), .out_flit(out_flit), .take(take),
    .at_barrier(at_barrier), .finished(finished)
  );

  inj_rx_tally #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rx_expected(rx_expected),
    .rx_count(rx_count), .done(done)
  );
endmodule

// File: rtl/traffic_injector_chk.sv
module traffic_injector_chk #(
  parameter int FW     = 17,
  parameter int RATE_W = 6,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RATE_W-1:0] rate,
  input logic              out_valid,
  input logic              out_bp,
  input logic [FW-1:0]     out_flit,
  input logic              in_valid,
  input logic              credit,
  input logic              carry,
  input logic              take,
  input logic              at_barrier,
  input logic              finished,
  input logic [CNT_W-1:0]  rx_count
);
  AST_HOLD_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bp |=> out_valid && $stable(out_flit)); // R8
  AST_SEND_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> credit); // R7
  AST_CREDIT_FROM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(credit) |-> $past(carry)); // R7
  AST_ZERO_RATE_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    rate == '0 |-> !carry); // R7
  AST_BARRIER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    at_barrier |-> !out_valid); // R5
  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> finished && !out_valid); // R6
  AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> rx_count == CNT_W'($past(rx_count) + 1'b1)); // R10
endmodule

bind traffic_injector traffic_injector_chk #(
  .FW(X_W + Y_W + LEN_W + PAY_W + 1), .RATE_W(RATE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rate(rate), .out_valid(out_valid), .out_bp(out_bp),
  .out_flit(out_flit), .in_valid(in_valid), .credit(credit), .carry(carry),
  .take(take), .at_barrier(at_barrier), .finished(finished), .rx_count(rx_count)
);

// File: tb/sim_traffic_injector.sv
`timescale 1ns/1ps
module sim_traffic_injector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0;
  logic [4:0]  ld_addr = '0;
  logic [10:0] ld_word = '0;
  logic        run = 1'b0;
  logic [5:0]  rate = '0;
  logic        step_go = 1'b0;
  logic        out_valid;
  logic [16:0] out_flit;
  logic        out_bp = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  rx_expected = 8'd5;
  logic        done;

  int total = 0;
  int fails = 0;
  int sent_cnt = 0;
  logic [16:0] exp_q[$];
  logic        prev_stall = 1'b0;
  logic [16:0] prev_flit = '0;

  always #2.5 clk = ~clk;

  traffic_injector u0 (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_word(ld_word),
    .run(run), .rate(rate), .step_go(step_go), .out_valid(out_valid),
    .out_flit(out_flit), .out_bp(out_bp), .in_valid(in_valid),
    .rx_expected(rx_expected), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic put_word(input int addr, input logic [10:0] w);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = addr[4:0]; ld_word = w;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // Driver: stores a packet record and queues its expected flits (R2, R3)
  task automatic put_packet(input int addr, input int dx, input int dy, input int len);
    put_word(addr, 11'((dx << 7) | (dy << 4) | len));
    if (len > 0) begin
      exp_q.push_back(17'((1 << 16) | (dx << 13) | (dy << 10) | (len << 6)));
      for (int k = 1; k < len; k++) exp_q.push_back(17'(k));
    end
  endtask

  // Monitor: compares every transferred flit and the hold rule
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && out_flit == prev_flit, "R8 hold under backpressure",
            {out_valid, out_flit}, {1'b1, prev_flit});
      if (out_valid && !out_bp) begin
        sent_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected flit", out_flit, 0);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk(out_flit == e, "R3 flit content/order", out_flit, e);
        end
      end
      prev_stall = out_valid && out_bp;
      prev_flit  = out_flit;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int snap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);

    // R9: load the trace while run is low
    for (int a = 0; a < 32; a++) put_word(a, 11'h7FF);
    put_packet(0, 2, 5, 3);
    put_packet(1, 7, 0, 1);
    put_packet(2, 1, 1, 0);          // R4 zero length
    put_word(3, 11'h405);            // R4 stray top-bit word
    put_word(4, 11'h400);            // R5 step marker
    put_packet(5, 3, 3, 2);
    put_packet(6, 4, 4, 15);
    put_packet(7, 5, 1, 15);
    put_packet(8, 6, 2, 15);         // address 9 stays an end marker (R6)

    @(negedge clk);
    run = 1'b1; rate = 6'd0;
    repeat (100) @(negedge clk);
    #1;
    chk(sent_cnt == 0, "R7 rate zero sends nothing", sent_cnt, 0);

    rate = 6'd63;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      out_bp = (i % 3 == 0);
    end
    @(negedge clk);
    out_bp = 1'b0;
    for (int i = 0; i < 200 && sent_cnt < 4; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    #1;
    chk(sent_cnt == 4, "R4/R5 flits before barrier", sent_cnt, 4);
    chk(exp_q.size() == 47, "R9 first records played from address 0", exp_q.size(), 47);

    @(negedge clk);
    rate = 6'd16; step_go = 1'b1;
    @(negedge clk);
    step_go = 1'b0;
    repeat (30) @(negedge clk);
    snap = sent_cnt;
    repeat (128) @(negedge clk);
    chk(sent_cnt - snap >= 31 && sent_cnt - snap <= 33, "R7 rate 16 window",
        sent_cnt - snap, 32);

    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (100) @(negedge clk);
    #1;
    chk(sent_cnt == 51, "R6 nothing after end marker", sent_cnt, 51);
    chk(exp_q.size() == 0, "R2 all expected flits seen", exp_q.size(), 0);
    chk(out_valid == 1'b0, "R6 idle after end", out_valid, 0);

    // R10 receive side
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_valid = 1'b1;
      @(negedge clk); in_valid = 1'b0;
    end
    #1;
    chk(done == 1'b0, "R10 done low at 4 of 5", done, 0);
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    #1;
    chk(done == 1'b1, "R10 done at 5 of 5", done, 1);
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    #1;
    chk(done == 1'b0, "R10 done drops past total", done, 0);
    rx_expected = 8'd6;
    #1;
    chk(done == 1'b1, "R10 done follows rx_expected", done, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule